// File: doc/BRIEF.md
# Chained Block Cipher Sequencer

This block sits between a register bus and a 128-bit block cipher core. Software loads a 128-bit data word, then writes a control word whose launch bit starts one cipher pass. In chained mode the block XORs the loaded data with the ciphertext kept from the previous pass before handing it to the core. This is the chaining step used for cipher-block chaining and for building message integrity codes. The block issues a one-cycle request to the core and waits a fixed number of clock cycles. It then captures the core's result into the data register and raises its completion status.

Two status flags report the outcome: a completion flag and a fault flag. Each flag clears as a side effect of a different access. Reading the status word clears the fault flag. Any read or write of the data word clears the completion flag. A ready interrupt pulse is gated by a local mask bit and a global enable. It is also held back unless both flags were already clear when the pass finished. With the mask clear, software polls the status word. No initialisation vector is applied in hardware: the chaining register is zero after reset and on every entry into chained mode, so software folds any vector into the first block.

Top module: `cbc_seq`

Bus map (`bus_sel`): 0 = control, 1 = status, 2 = data. Control bits: bit 0 launch (write-only, reads 0), bit 1 chained mode, bit 2 interrupt mask. Status bits: bit 0 completion, bit 1 fault, bit 2 busy.

## Requirements
- R1: After reset the status word reads 0, the data word reads 0 and `ready_irq` is low.
- R2: A control write with bit 0 set while idle gives exactly one single-cycle `core_req` pulse. After the pass the data word holds `core_dout`, and status bit 0 reads 1.
- R3: In chained mode (control bit 1 = 1) `core_din` equals the data word XOR the result of the previous chained pass. In plain mode `core_din` equals the data word.
- R4: The chaining register is zero after reset and after each control write that changes bit 1 from 0 to 1, so the next chained `core_din` equals the data word alone.
- R5: When `core_err` is high at the end of a pass, status bit 1 is set. After a clean pass bit 1 stays 0 and bit 0 is 1.
- R6: A status read clears status bit 1 and leaves bit 0 unchanged.
- R7: A read or a write of the data word clears status bit 0.
- R8: `ready_irq` never fires unless control bit 2 and `global_irq_en` are both 1.
- R9: `ready_irq` is a one-cycle pulse at the end of a pass. It fires only if status bits 0 and 1 were both clear at that moment.
- R10: A launch while busy issues no new request and does not disturb the running pass. Status bit 1 is set when that pass ends. Status bit 2 reads 1 while a pass runs.
- R11: A pass lasts LAT = CLK_HZ × PROC_NS / 10^9 cycles (1200 at the defaults). Status bit 0 is still 0 one cycle before completion and reads 1 after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives read side effects) |
| bus_sel | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wdata | input | 128 | Write data |
| bus_rdata | output | 128 | Read data for the selected register (combinational) |
| global_irq_en | input | 1 | Global interrupt enable |
| ready_irq | output | 1 | One-cycle ready interrupt pulse |
| core_req | output | 1 | One-cycle request to the cipher core |
| core_din | output | 128 | Block handed to the core, valid from `core_req` on |
| core_dout | input | 128 | Core result, sampled at the end of the pass |
| core_err | input | 1 | Core fault indication, sampled at the end of the pass |

## Verification
The hardest case is the interrupt hold-off. The stimulus must end a pass while a fault flag set by an earlier pass is still pending. To do that, the bench injects a core fault on one pass. It then clears only the completion flag, with a data write, before launching the next pass. The missing interrupt shows that the pending fault blocked it. A second launch sent mid-pass, ten cycles in, covers the ignored-launch case. The scoreboard then must see only one core request, and the fault must appear at completion.

// File: rtl/cbc_seq_pkg.sv
// Package: shared constants for the chained cipher sequencer.
// Assumes a 2-bit register select and fixed bit positions in the control
// and status words, which software depends on.
package cbc_seq_pkg;
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_STAT = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;

    localparam int CTL_GO    = 0;
    localparam int CTL_CHAIN = 1;
    localparam int CTL_MASK  = 2;

    localparam int ST_DONE = 0;
    localparam int ST_FLT  = 1;
    localparam int ST_BUSY = 2;

    // Pass length in cycles from clock rate and processing time; never below 1.
    function automatic int lat_cycles(input longint clk_hz, input longint proc_ns);
        longint c;
        c = (clk_hz * proc_ns) / 64'd1_000_000_000;
        return (c < 1) ? 1 : int'(c);
    endfunction
endpackage

// File: rtl/cbc_seq_timer.sv
// Pass timer: counts a fixed number of cycles per cipher pass.
// Assumes launch is only asserted while idle (the top gates it with busy).
module cbc_seq_timer #(
    parameter int LAT   = 1200,
    localparam int CNT_W = $clog2(LAT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic busy,
    output logic core_req,
    output logic finish
);
    logic [CNT_W-1:0] cnt_q;

    assign finish = busy && (cnt_q == '0);

    // Load the counter on launch, count down while busy, drop busy at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cnt_q    <= '0;
            core_req <= 1'b0;
        end else begin
            core_req <= launch;
            if (launch) begin
                busy  <= 1'b1;
                cnt_q <= CNT_W'(LAT - 1);
            end else if (finish) begin
                busy <= 1'b0;
            end else if (busy) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        core_req |=> !core_req);                                   // R2
    AST_REQ_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        core_req |-> busy);                                        // R2
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish) |=> busy);                               // R10
endmodule

// File: rtl/cbc_seq_datapath.sv
// Data path: holds the software data word and the chaining register,
// forms the core input, and captures the core result at pass end.
// Assumes at most one bus access per cycle.
module cbc_seq_datapath #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         data_wr,
    input  logic [W-1:0] wdata,
    input  logic         chain_mode,
    input  logic         chain_clr,
    input  logic         launch,
    input  logic         finish,
    input  logic [W-1:0] core_dout,
    output logic [W-1:0] state_q,
    output logic [W-1:0] core_din
);
    logic [W-1:0] chain_q;
    logic [W-1:0] chain_eff;

    // Chaining value seen by this launch (zero on the cycle of mode entry).
    always_comb chain_eff = chain_clr ? '0 : chain_q;

    // Data word: loaded by software, replaced by the core result at pass end.
    always_ff @(posedge clk) begin
        if (!rst_n)       state_q <= '0;
        else if (finish)  state_q <= core_dout;
        else if (data_wr) state_q <= wdata;
    end

    // Chaining register: cleared on mode entry, updated after chained passes.
    always_ff @(posedge clk) begin
        if (!rst_n)                     chain_q <= '0;
        else if (chain_clr)             chain_q <= '0;
        else if (finish && chain_mode)  chain_q <= core_dout;
    end

    // Core input register: latched at launch.
    always_ff @(posedge clk) begin
        if (!rst_n)      core_din <= '0;
        else if (launch) core_din <= chain_mode ? (state_q ^ chain_eff) : state_q;
    end

    AST_CHAIN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_clr && !finish) |=> (chain_q == '0));               // R4
endmodule

// File: rtl/cbc_seq_status.sv
// Status flags and ready interrupt. Completion clears on a data access,
// fault clears on a status read, setting beats clearing, and the interrupt
// is held back unless both flags are clear when a pass ends.
module cbc_seq_status (
    input  logic clk,
    input  logic rst_n,
    input  logic finish,
    input  logic core_err,
    input  logic lost_start,
    input  logic stat_rd,
    input  logic data_acc,
    input  logic irq_mask,
    input  logic gie,
    output logic done_q,
    output logic flt_q,
    output logic irq
);
    logic lost_q;

    // Remember a launch refused during the running pass.
    always_ff @(posedge clk) begin
        if (!rst_n)          lost_q <= 1'b0;
        else if (finish)     lost_q <= 1'b0;
        else if (lost_start) lost_q <= 1'b1;
    end

    // Fault flag: set at pass end on core fault or refused launch.
    always_ff @(posedge clk) begin
        if (!rst_n)                                        flt_q <= 1'b0;
        else if (finish && (core_err || lost_q || lost_start)) flt_q <= 1'b1;
        else if (stat_rd)                                  flt_q <= 1'b0;
    end

    // Completion flag: set at pass end, cleared by a data access.
    always_ff @(posedge clk) begin
        if (!rst_n)        done_q <= 1'b0;
        else if (finish)   done_q <= 1'b1;
        else if (data_acc) done_q <= 1'b0;
    end

    // Ready interrupt: one pulse per qualified pass end.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= finish && irq_mask && gie && !done_q && !flt_q;
    end

    AST_FLT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !finish) |=> !flt_q);                          // R6
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !finish) |=> !done_q);                        // R7
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);                                             // R9
    AST_IRQ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done_q);                                           // R9
endmodule

// File: rtl/cbc_seq.sv
// Top: register decode for control, status and data words, and wiring of
// timer, data path and status logic. Assumes one bus access per cycle and a
// core whose result is stable before the pass timer expires.
module cbc_seq
    import cbc_seq_pkg::*;
#(
    parameter longint CLK_HZ  = 50_000_000,
    parameter longint PROC_NS = 24_000,
    parameter int     W       = 128,
    localparam int    LAT     = lat_cycles(CLK_HZ, PROC_NS)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_wr,
    input  logic         bus_rd,
    input  logic [1:0]   bus_sel,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic         global_irq_en,
    output logic         ready_irq,
    output logic         core_req,
    output logic [W-1:0] core_din,
    input  logic [W-1:0] core_dout,
    input  logic         core_err
);
    logic ctrl_wr, data_wr, data_acc, stat_rd;
    logic go_req, launch, lost_start, chain_clr, chain_next;
    logic chain_q, mask_q;
    logic busy, finish, done_q, flt_q;
    logic [W-1:0] state_q;

    // Bus decode.
    always_comb begin
        ctrl_wr    = bus_wr && (bus_sel == SEL_CTRL);
        data_wr    = bus_wr && (bus_sel == SEL_DATA);
        data_acc   = (bus_wr || bus_rd) && (bus_sel == SEL_DATA);
        stat_rd    = bus_rd && (bus_sel == SEL_STAT);
        go_req     = ctrl_wr && bus_wdata[CTL_GO];
        launch     = go_req && !busy;
        lost_start = go_req && busy;
        chain_next = ctrl_wr ? bus_wdata[CTL_CHAIN] : chain_q;
        chain_clr  = ctrl_wr && bus_wdata[CTL_CHAIN] && !chain_q;
    end

    // Control register: mode and interrupt mask bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= 1'b0;
            mask_q  <= 1'b0;
        end else if (ctrl_wr) begin
            chain_q <= bus_wdata[CTL_CHAIN];
            mask_q  <= bus_wdata[CTL_MASK];
        end
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_sel)
            SEL_CTRL: begin
                bus_rdata[CTL_CHAIN] = chain_q;
                bus_rdata[CTL_MASK]  = mask_q;
            end
            SEL_STAT: begin
                bus_rdata[ST_DONE] = done_q;
                bus_rdata[ST_FLT]  = flt_q;
                bus_rdata[ST_BUSY] = busy;
            end
            SEL_DATA: bus_rdata = state_q;
            default:  bus_rdata = '0;
        endcase
    end

    cbc_seq_timer #(.LAT(LAT)) u_timer (
        .clk(clk), .rst_n(rst_n), .launch(launch),
        .busy(busy), .core_req(core_req), .finish(finish)
    );

    cbc_seq_datapath #(.W(W)) u_path (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .wdata(bus_wdata),
        .chain_mode(chain_next), .chain_clr(chain_clr), .launch(launch),
        .finish(finish), .core_dout(core_dout),
        .state_q(state_q), .core_din(core_din)
    );

    cbc_seq_status u_stat (
        .clk(clk), .rst_n(rst_n), .finish(finish), .core_err(core_err),
        .lost_start(lost_start), .stat_rd(stat_rd), .data_acc(data_acc),
        .irq_mask(mask_q), .gie(global_irq_en),
        .done_q(done_q), .flt_q(flt_q), .irq(ready_irq)
    );

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ready_irq |-> $past(mask_q && global_irq_en));             // R8
    AST_NO_REQ_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish) |=> !core_req);                          // R10
endmodule

// File: tb/cbc_seq_bench.sv
// Scoreboard bench: driver tasks push expected core inputs, a monitor pops
// and compares them on each core request; register checks via bus reads.
module cbc_seq_bench;
    localparam int W   = 128;
    localparam int LAT = 1200;          // 50 MHz x 24 us
    localparam logic [W-1:0] KEY = 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]   bus_sel = 2'd0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         gie = 1'b0;
    logic         ready_irq, core_req;
    logic [W-1:0] core_din;
    logic [W-1:0] core_dout = '0;
    logic         core_err = 1'b0;

    int checks = 0, fails = 0, irq_cnt = 0;
    bit irq_prev = 1'b0;
    logic [W-1:0] exp_q[$];
    logic [W-1:0] m_chain = '0;

    always #10 clk = ~clk;

    cbc_seq u_cbc_seq (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .global_irq_en(gie), .ready_irq(ready_irq), .core_req(core_req),
        .core_din(core_din), .core_dout(core_dout), .core_err(core_err)
    );

    function automatic logic [W-1:0] ciph(input logic [W-1:0] x);
        return {x[W-2:0], x[W-1]} ^ KEY;
    endfunction

    // Core stub: result ready one cycle after the request.
    always @(posedge clk) if (core_req) core_dout <= ciph(core_din);

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: each core request pops one expected input (R2, R3, R4, R10).
    always @(negedge clk) begin
        if (rst_n && core_req) begin
            if (exp_q.size() == 0) chk(1'b0, "R10 unexpected core_req", core_din, '0);
            else begin
                logic [W-1:0] e;
                e = exp_q.pop_front();
                chk(core_din == e, "R3 core_din", core_din, e);
            end
        end
        if (rst_n && ready_irq) begin
            irq_cnt++;
            if (irq_prev) chk(1'b0, "R9 irq wider than one cycle", 1, 0);
        end
        irq_prev = ready_irq;
    end

    task automatic wr(input logic [1:0] s, input logic [W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = s; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [W-1:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_sel = s;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Control write without launch; entering chained mode zeroes the model chain.
    task automatic set_ctrl(input bit ch, input bit mk, input bit cur_ch);
        if (ch && !cur_ch) m_chain = '0;
        wr(2'd0, {125'd0, mk, ch, 1'b0});
    endtask

    // One full pass: load data, launch, wait past completion.
    task automatic pass(input logic [W-1:0] pt, input bit ch, input bit mk, output logic [W-1:0] res);
        logic [W-1:0] e;
        wr(2'd2, pt);
        e = ch ? (pt ^ m_chain) : pt;
        exp_q.push_back(e);
        wr(2'd0, {125'd0, mk, ch, 1'b1});
        repeat (LAT + 2) @(negedge clk);
        res = ciph(e);
        if (ch) m_chain = res;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [W-1:0] v, r, e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd1, v); chk(v == '0, "R1 status after reset", v, '0);
        rd(2'd2, v); chk(v == '0, "R1 data after reset", v, '0);
        chk(ready_irq == 1'b0, "R1 irq after reset", ready_irq, 0);

        // R2/R5/R8 plain pass, mask off
        gie = 1'b1;
        pass(128'h00112233445566778899AABBCCDDEEFF, 1'b0, 1'b0, r);
        rd(2'd1, v); chk(v == 128'd1, "R5 clean pass status", v, 128'd1);
        rd(2'd1, v); chk(v == 128'd1, "R6 status read keeps done", v, 128'd1);
        chk(irq_cnt == 0, "R8 no irq with mask clear", irq_cnt, 0);
        rd(2'd2, v); chk(v == r, "R2 result in data word", v, r);
        rd(2'd1, v); chk(v == '0, "R7 data read clears done", v, '0);

        // R4 chain entry, R9 irq, R3 chaining
        set_ctrl(1'b1, 1'b1, 1'b0);
        pass(128'hCAFEF00D_DEADBEEF_01234567_89ABCDEF, 1'b1, 1'b1, r);
        chk(irq_cnt == 1, "R9 irq after clean chained pass", irq_cnt, 1);
        rd(2'd2, v); chk(v == r, "R3 first chained result", v, r);
        pass(128'h11111111_22222222_33333333_44444444, 1'b1, 1'b1, r);
        chk(irq_cnt == 2, "R9 second irq", irq_cnt, 2);

        // R5 core fault, then R9 hold-off by pending fault
        core_err = 1'b1;
        pass(128'h55555555_66666666_77777777_88888888, 1'b1, 1'b1, r);
        core_err = 1'b0;
        chk(irq_cnt == 3, "R9 irq on faulted pass", irq_cnt, 3);
        pass(128'h99999999_AAAAAAAA_BBBBBBBB_CCCCCCCC, 1'b1, 1'b1, r);
        chk(irq_cnt == 3, "R9 irq blocked by pending fault", irq_cnt, 3);
        rd(2'd1, v); chk(v == 128'd3, "R5 fault and done set", v, 128'd3);
        rd(2'd1, v); chk(v == 128'd1, "R6 status read cleared fault", v, 128'd1);
        rd(2'd2, v); chk(v == r, "R3 chained result after fault", v, r);

        // R8 global enable off
        gie = 1'b0;
        pass(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 1'b1, 1'b1, r);
        chk(irq_cnt == 3, "R8 no irq with global enable off", irq_cnt, 3);
        gie = 1'b1;

        // R10 launch while busy
        wr(2'd2, 128'hA5A5A5A5_5A5A5A5A_A5A5A5A5_5A5A5A5A);
        rd(2'd1, v);   // clear fault, if any
        e = 128'hA5A5A5A5_5A5A5A5A_A5A5A5A5_5A5A5A5A ^ m_chain;
        exp_q.push_back(e);
        wr(2'd0, {125'd0, 1'b0, 1'b1, 1'b1});
        repeat (10) @(negedge clk);
        rd(2'd1, v); chk(v[2] == 1'b1, "R10 busy during pass", v, 128'd4);
        wr(2'd0, {125'd0, 1'b0, 1'b1, 1'b1});
        repeat (LAT) @(negedge clk);
        r = ciph(e); m_chain = r;
        rd(2'd1, v); chk(v == 128'd3, "R10 fault after refused launch", v, 128'd3);
        rd(2'd2, v); chk(v == r, "R10 running pass undisturbed", v, r);

        // R4 mode re-entry resets chain
        set_ctrl(1'b0, 1'b0, 1'b1);
        set_ctrl(1'b1, 1'b0, 1'b0);
        pass(128'h0BADC0DE_0BADC0DE_0BADC0DE_0BADC0DE, 1'b1, 1'b0, r);
        rd(2'd2, v); chk(v == r, "R4 chain zero after re-entry", v, r);

        // R11 exact pass length
        wr(2'd2, 128'h1234);
        rd(2'd1, v);
        exp_q.push_back(128'h1234);
        wr(2'd0, {125'd0, 3'b001});
        repeat (LAT - 2) @(negedge clk);
        rd(2'd1, v); chk(v == 128'd4, "R11 still busy before last cycle", v, 128'd4);
        rd(2'd1, v); chk(v == 128'd1, "R11 done after LAT cycles", v, 128'd1);

        chk(exp_q.size() == 0, "R2 all requests seen", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule